// File: doc/BRIEF.md
# Power-On Reset Sequencer with Configuration Strap Capture

This block produces the internal reset of a network controller from two sources. One is an active-low reset pin. The other is a power-up request, `por_start`, which stands in for analog power-on detection. Either source pulls the internal reset low at once, without waiting for a clock. The release of the internal reset follows the clock. After a power-up, the block keeps the device in reset for a fixed interval of about 23 ms. That interval is computed from the clock frequency parameter and a time parameter given in microseconds, so a testbench can shrink it. After a pin-only reset, no power-up interval runs: the internal reset releases as soon as the synchroniser lets go.

At the clock edge where the internal reset releases, the block samples two strap pins and holds what it reads until the next reset:

- The width strap selects a 32-bit host bus (1) or a 16-bit host bus (0).
- The speed strap selects the default link setup. A value of 0 gives 10 Mb/s, half duplex, auto-negotiation off. A value of 1 gives 100 Mb/s, half duplex, auto-negotiation on.

A ready flag rises a fixed number of cycles after the internal reset releases, to model internal settling. Software polls this flag before it uses the device.

The sequencer is a four-state machine:

- **ST_RESET**: internal reset held. It is entered asynchronously while either reset source is active.
- **ST_POR_WAIT**: the power-up interval is counting.
- **ST_SETTLE**: internal reset released, ready flag still low.
- **ST_READY**: operational.

The transitions are:

- **ST_RESET → ST_POR_WAIT**: taken when a power-up is pending.
- **ST_RESET → ST_SETTLE**: taken on a pin-only reset. The straps are captured on this edge.
- **ST_POR_WAIT → ST_SETTLE**: taken when the interval has elapsed. The straps are captured on this edge and the pending power-up is cleared.
- **ST_SETTLE → ST_READY**: taken after the settle count.
- **Any state → ST_RESET**: taken asynchronously on either reset source.

Top module: `por_strap_ctrl`

## Requirements
- R1: While `ext_rst_n` is low or `por_start` is high, `sys_rst_n` and `dev_ready` are low immediately, with no clock edge needed.
- R2: After `por_start` falls (with `ext_rst_n` high), `sys_rst_n` rises on the (3 + HOLD_CYC)-th rising clock edge. HOLD_CYC = CLK_HZ × HOLD_US / 1,000,000.
- R3: When no power-up is pending, `sys_rst_n` rises on the 3rd rising clock edge after `ext_rst_n` rises.
- R4: A pin reset that arrives before the power-up interval completes does not cancel it. After `ext_rst_n` rises, the full (3 + HOLD_CYC) edge wait applies.
- R5: `dev_ready` rises exactly READY_DLY clock edges after `sys_rst_n` rises. Once high, it stays high until a reset source is asserted. It is never high while `sys_rst_n` is low.
- R6: `cfg_bus32` equals the value of `strap_width` at the releasing edge: 1 means 32-bit, 0 means 16-bit.
- R7: A speed strap of 0 at release gives `cfg_speed100`=0, `cfg_full_duplex`=0, `cfg_autoneg`=0.
- R8: A speed strap of 1 at release gives `cfg_speed100`=1, `cfg_full_duplex`=0, `cfg_autoneg`=1.
- R9: After release, changes on `strap_width` and `strap_speed` leave every configuration output unchanged until the next reset.
- R10: While `sys_rst_n` is low, all four configuration outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_start | input | 1 | Power-up request, active high, asserts asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asserts asynchronously |
| strap_width | input | 1 | Host bus width strap |
| strap_speed | input | 1 | Default link setup strap |
| sys_rst_n | output | 1 | Internal reset, active low, released synchronously |
| cfg_bus32 | output | 1 | Latched bus width: 1 = 32-bit |
| cfg_speed100 | output | 1 | Latched default speed: 1 = 100 Mb/s |
| cfg_full_duplex | output | 1 | Latched default duplex: 1 = full |
| cfg_autoneg | output | 1 | Latched auto-negotiation enable |
| dev_ready | output | 1 | Device ready flag |

## Verification
The checker assumes three things about the inputs:

- `por_start` is pulsed at least once before the first release, so that the pending power-up flag has a defined value.
- Both reset sources are treated as disabling conditions.
- The straps are stable across the releasing clock edge.

The stimulus keeps to these assumptions. It starts with `por_start` high at time zero. It changes straps and reset inputs only on falling clock edges. It holds each reset source for several cycles, so that the synchroniser always sees a clean pulse.

// File: rtl/porcfg_pkg.sv
package porcfg_pkg;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_POR_WAIT = 2'd1,
        ST_SETTLE   = 2'd2,
        ST_READY    = 2'd3
    } pc_state_e;

    typedef struct packed {
        logic bus32;
        logic speed100;
        logic full_dup;
        logic autoneg;
    } strap_cfg_t;

    // One speed strap expands to a whole default link setup
    function automatic strap_cfg_t decode_straps(input logic width, input logic speed);
        strap_cfg_t c;
        c.bus32    = width;
        c.speed100 = speed;
        c.full_dup = 1'b0;
        c.autoneg  = speed;
        return c;
    endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
    import porcfg_pkg::*;
#(
    parameter int HOLD_CYC  = 575000,
    parameter int READY_DLY = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por_req,
    output logic      int_rst_n,
    output logic      ready,
    output logic      capture
);
    localparam int MAXC = (HOLD_CYC > READY_DLY) ? HOLD_CYC : READY_DLY;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] RDY_LAST  = CW'(READY_DLY - 1);

    pc_state_e     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          por_pend;
    logic          hold_done;

    assign hold_done = (state == ST_POR_WAIT) && (cnt == HOLD_LAST);

    // Power-up request is remembered until its interval has fully elapsed
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req)        por_pend <= 1'b1;
        else if (hold_done) por_pend <= 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            ST_RESET: begin
                cnt_nx   = '0;
                state_nx = por_pend ? ST_POR_WAIT : ST_SETTLE;
            end
            ST_POR_WAIT: begin
                if (cnt == HOLD_LAST) begin
                    state_nx = ST_SETTLE;
                    cnt_nx   = '0;
                end
            end
            ST_SETTLE: begin
                if (cnt == RDY_LAST) begin
                    state_nx = ST_READY;
                    cnt_nx   = '0;
                end
            end
            ST_READY: cnt_nx = cnt;
            default: begin
                state_nx = ST_RESET;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        int_rst_n = 1'b0;
        ready     = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_RESET:    capture   = !por_pend;
            ST_POR_WAIT: capture   = hold_done;
            ST_SETTLE:   int_rst_n = 1'b1;
            ST_READY: begin
                int_rst_n = 1'b1;
                ready     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import porcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       width_pin,
    input  logic       speed_pin,
    output strap_cfg_t cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg <= '0;
        else if (capture) cfg <= decode_straps(width_pin, speed_pin);
    end
endmodule

// File: rtl/por_strap_ctrl.sv
module por_strap_ctrl
    import porcfg_pkg::*;
#(
    parameter int CLK_HZ    = 25_000_000,
    parameter int HOLD_US   = 23_000,
    parameter int READY_DLY = 16
) (
    input  logic clk,
    input  logic por_start,
    input  logic ext_rst_n,
    input  logic strap_width,
    input  logic strap_speed,
    output logic sys_rst_n,
    output logic cfg_bus32,
    output logic cfg_speed100,
    output logic cfg_full_duplex,
    output logic cfg_autoneg,
    output logic dev_ready
);
    localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(HOLD_US)) / 64'd1000000;
    localparam int     HOLD_CYC = (HOLD_L < 1) ? 1 : int'(HOLD_L);
    localparam int     RDY_CYC  = (READY_DLY < 1) ? 1 : READY_DLY;

    logic       arst_n;
    logic       srst_n;
    logic       capture;
    strap_cfg_t cfg;

    assign arst_n = ext_rst_n & ~por_start;

    rst_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .srst_n (srst_n)
    );

    por_seq_fsm #(.HOLD_CYC(HOLD_CYC), .READY_DLY(RDY_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (srst_n),
        .por_req   (por_start),
        .int_rst_n (sys_rst_n),
        .ready     (dev_ready),
        .capture   (capture)
    );

    strap_capture u_cap (
        .clk       (clk),
        .rst_n     (srst_n),
        .capture   (capture),
        .width_pin (strap_width),
        .speed_pin (strap_speed),
        .cfg       (cfg)
    );

    assign cfg_bus32       = cfg.bus32;
    assign cfg_speed100    = cfg.speed100;
    assign cfg_full_duplex = cfg.full_dup;
    assign cfg_autoneg     = cfg.autoneg;
endmodule

// File: rtl/por_strap_ctrl_chk.sv
module por_strap_ctrl_chk (
    input logic clk,
    input logic por_start,
    input logic ext_rst_n,
    input logic sys_rst_n,
    input logic cfg_bus32,
    input logic cfg_speed100,
    input logic cfg_full_duplex,
    input logic cfg_autoneg,
    input logic dev_ready
);
    // R5
    ready_needs_rst_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        dev_ready |-> sys_rst_n);

    // R5
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        dev_ready |=> dev_ready);

    // R5
    ready_after_rel_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        $rose(dev_ready) |-> $past(sys_rst_n));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        (sys_rst_n && $past(sys_rst_n)) |->
            ($stable(cfg_bus32) && $stable(cfg_speed100) && $stable(cfg_autoneg) && $stable(cfg_full_duplex)));

    // R10
    cfg_clear_in_rst_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        !sys_rst_n |-> !(cfg_bus32 || cfg_speed100 || cfg_autoneg || cfg_full_duplex));

    // R8
    speed_an_pair_chk: assert property (@(posedge clk) disable iff (!ext_rst_n || por_start)
        sys_rst_n |-> (cfg_autoneg == cfg_speed100) && !cfg_full_duplex);
endmodule

bind por_strap_ctrl por_strap_ctrl_chk u_chk (
    .clk             (clk),
    .por_start       (por_start),
    .ext_rst_n       (ext_rst_n),
    .sys_rst_n       (sys_rst_n),
    .cfg_bus32       (cfg_bus32),
    .cfg_speed100    (cfg_speed100),
    .cfg_full_duplex (cfg_full_duplex),
    .cfg_autoneg     (cfg_autoneg),
    .dev_ready       (dev_ready)
);

// File: tb/por_strap_ctrl_tb.sv
`timescale 1ns/1ps
module por_strap_ctrl_tb;
    localparam int CLK_PER  = 10;
    localparam int T_CLK_HZ = 1_000_000;
    localparam int T_HOLDUS = 40;
    localparam int T_RDY    = 5;
    localparam int HOLD     = T_CLK_HZ / 1_000_000 * T_HOLDUS;

    logic clk = 1'b0;
    logic por_start = 1'b1;
    logic ext_rst_n = 1'b1;
    logic strap_width = 1'b0;
    logic strap_speed = 1'b0;
    logic sys_rst_n, cfg_bus32, cfg_speed100, cfg_full_duplex, cfg_autoneg, dev_ready;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    por_strap_ctrl #(.CLK_HZ(T_CLK_HZ), .HOLD_US(T_HOLDUS), .READY_DLY(T_RDY)) u_dut (
        .clk(clk), .por_start(por_start), .ext_rst_n(ext_rst_n),
        .strap_width(strap_width), .strap_speed(strap_speed),
        .sys_rst_n(sys_rst_n), .cfg_bus32(cfg_bus32), .cfg_speed100(cfg_speed100),
        .cfg_full_duplex(cfg_full_duplex), .cfg_autoneg(cfg_autoneg), .dev_ready(dev_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_to_rel(output int n);
        n = 0;
        while (!sys_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_to_ready(output int n);
        n = 0;
        while (!dev_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic chk_cfg(input logic w, input logic s);
        chk(cfg_bus32 == w, "R6 bus width", int'(cfg_bus32), int'(w));
        chk(cfg_speed100 == s, s ? "R8 speed" : "R7 speed", int'(cfg_speed100), int'(s));
        chk(cfg_autoneg == s, s ? "R8 autoneg" : "R7 autoneg", int'(cfg_autoneg), int'(s));
        chk(cfg_full_duplex == 1'b0, s ? "R8 duplex" : "R7 duplex", int'(cfg_full_duplex), 0);
    endtask

    task automatic t_power_up(input logic w, input logic s);
        int n;
        @(negedge clk);
        por_start = 1'b1; strap_width = w; strap_speed = s;
        #1;
        chk(!sys_rst_n && !dev_ready, "R1 por asserted", int'(sys_rst_n), 0);
        chk(!(cfg_bus32 | cfg_speed100 | cfg_autoneg | cfg_full_duplex), "R10 cfg in reset",
            int'({cfg_bus32, cfg_speed100, cfg_autoneg, cfg_full_duplex}), 0);
        repeat (3) @(negedge clk);
        por_start = 1'b0;
        count_to_rel(n);
        chk(n == HOLD + 3, "R2 power-up hold", n, HOLD + 3);
        count_to_ready(n);
        chk(n == T_RDY, "R5 ready delay", n, T_RDY);
        chk_cfg(w, s);
    endtask

    task automatic t_ext_reset(input logic w, input logic s);
        int n;
        @(negedge clk);
        ext_rst_n = 1'b0; strap_width = w; strap_speed = s;
        #1;
        chk(!sys_rst_n && !dev_ready, "R1 pin asserted", int'(dev_ready), 0);
        repeat (3) @(negedge clk);
        chk(!(cfg_bus32 | cfg_speed100 | cfg_autoneg), "R10 cfg cleared",
            int'({cfg_bus32, cfg_speed100, cfg_autoneg}), 0);
        ext_rst_n = 1'b1;
        count_to_rel(n);
        chk(n == 3, "R3 pin-only release", n, 3);
        count_to_ready(n);
        chk(n == T_RDY, "R5 ready delay pin", n, T_RDY);
        chk_cfg(w, s);
    endtask

    task automatic t_strap_ignore();
        logic w0, s0;
        w0 = cfg_bus32; s0 = cfg_speed100;
        @(negedge clk);
        strap_width = ~w0; strap_speed = ~s0;
        repeat (20) @(negedge clk);
        strap_width = w0;
        repeat (5) @(negedge clk);
        chk(cfg_bus32 == w0, "R9 width ignored", int'(cfg_bus32), int'(w0));
        chk(cfg_speed100 == s0 && cfg_autoneg == s0, "R9 speed ignored", int'(cfg_speed100), int'(s0));
        chk(sys_rst_n && dev_ready, "R9 still operational", int'(dev_ready), 1);
    endtask

    task automatic t_pin_during_por();
        int n;
        @(negedge clk);
        por_start = 1'b1; strap_width = 1'b1; strap_speed = 1'b0;
        repeat (3) @(negedge clk);
        por_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(!sys_rst_n, "R4 still holding", int'(sys_rst_n), 0);
        ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
        count_to_rel(n);
        chk(n == HOLD + 3, "R4 hold restarted", n, HOLD + 3);
        count_to_ready(n);
        chk(n == T_RDY, "R5 ready after R4", n, T_RDY);
        chk_cfg(1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        chk(!sys_rst_n && !dev_ready, "R1 reset state", int'(sys_rst_n), 0);
        t_power_up(1'b1, 1'b1);
        t_strap_ignore();
        t_ext_reset(1'b0, 1'b0);
        t_ext_reset(1'b1, 1'b0);
        t_power_up(1'b0, 1'b1);
        t_strap_ignore();
        t_pin_during_por();
        t_ext_reset(1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule